// File: doc/BRIEF.md
# Memory Power-Down Sequencer

This block sits between the command scheduler of a DRAM controller and the memory pins. It decides when the device may drop into its low-power state, and it drives the device's active-low clock-enable line. A HIGH level on that line means the device is powered down. The scheduler raises a power-down request when it has nothing left to do. The sequencer grants entry only once no read or write is still running, counting each access up to the end of its postamble. It then records whether any bank held an open row, which classifies the state as active or precharge power-down.

After entry the block takes over the command bus and forces NOP cycles. It keeps the scheduler blocked until exit is complete and the exit latency has run out. Exit happens when the request drops or when a refresh deadline comes due. An exit request that arrives while the line must still hold its level is latched and carried out as soon as the minimum pulse width allows. The minimum pulse width and the exit latency are run-time inputs.

Top module: `mem_pd_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cke_n` is LOW, `cmd_block` and `force_nop` are LOW, and `pd_mode` is 2'b00.
- R2: `cke_n` rises only after an edge at which `pd_req` is HIGH and `rd_busy`, `wr_busy` and `ref_due` are all LOW. While either busy flag is HIGH, `cke_n` stays LOW.
- R3: `pd_mode` reads 2'b01 (precharge) if no bit of `bank_open` was set at the entry edge, and 2'b10 (active) if any bit was set. The value holds for as long as `cke_n` is HIGH. It reads 2'b00 whenever `cke_n` is LOW.
- R4: `force_nop` is HIGH in the first cycle that `cke_n` is HIGH and in the two cycles that follow. It is LOW in the fourth cycle.
- R5: After `cke_n` changes level, it keeps the new level for at least max(1, `cfg_tcke`) cycles before it may change again. This applies in both directions.
- R6: An exit request seen during the entry NOP cycles or during power-down is latched. An exit request is `pd_req` LOW or `ref_due` HIGH. The latched request causes exit at the first power-down cycle in which R5 allows it, even if the request has gone away by then.
- R7: In the first cycle with `cke_n` LOW after power-down, `force_nop` and `cmd_block` are HIGH.
- R8: `cmd_block` is HIGH from the first cycle that `cke_n` is HIGH. It falls exactly max(1, `cfg_tpdex`) cycles after the first cycle that `cke_n` is LOW again.
- R9: A HIGH `ref_due` prevents entry. While the device is powered down, a HIGH `ref_due` forces exit even though `pd_req` stays HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tcke | input | CNT_W | Minimum number of cycles the enable line holds a level |
| cfg_tpdex | input | CNT_W | Number of cycles from exit until a valid command is allowed |
| pd_req | input | 1 | Scheduler is idle and asks for power-down |
| bank_open | input | NUM_BANKS | One bit per bank, HIGH if the bank has an open row |
| rd_busy | input | 1 | A read is running, up to the end of its postamble |
| wr_busy | input | 1 | A write is running, up to the end of its postamble |
| ref_due | input | 1 | Refresh deadline pending |
| cke_n | output | 1 | Active-low clock enable, HIGH means powered down |
| cmd_block | output | 1 | Scheduler may issue only NOP or DESELECT |
| force_nop | output | 1 | Sequencer drives NOP on the command bus |
| pd_mode | output | 2 | 00 none, 01 precharge power-down, 10 active power-down |

## Verification
The hardest case to reach from the ports is an exit request that comes and goes inside the three entry NOP cycles, before the minimum pulse width is met. Whether exit still happens then depends on the latch alone. The stimulus lowers `pd_req` in the cycle right after entry and raises it again two cycles later. In a second run it pulses `ref_due` for a single entry cycle with `pd_req` held HIGH. In both runs the bench expects exit in the first power-down cycle. A further run checks the enable-line hold in the other direction. There the exit latency is set shorter than the minimum pulse width, and the request is held HIGH so that re-entry is pending. The bench then expects re-entry to wait for the pulse width rather than for the latency.

// File: rtl/pds_pkg.sv
// Package: shared types for the memory power-down sequencer.
// Assumes: consumers import it; the encodings are visible on ports.
package pds_pkg;

    // Sequencer control states
    typedef enum logic [1:0] {
        PDS_ACTIVE    = 2'd0,
        PDS_ENTRY_NOP = 2'd1,
        PDS_DOWN      = 2'd2,
        PDS_EXIT_WAIT = 2'd3
    } pds_state_e;

    // Power-down class reported on pd_mode
    typedef enum logic [1:0] {
        PDM_NONE      = 2'b00,
        PDM_PRECHARGE = 2'b01,
        PDM_ACTIVE    = 2'b10
    } pds_mode_e;

    // Number of forced NOP cycles that follow the entry cycle
    localparam int unsigned PDS_POST_ENTRY_NOPS = 2;

endpackage

// File: rtl/pds_dncnt.sv
// Module: pds_dncnt
// Loadable down-counter that stops at zero. It is used for the
// enable-line hold time, the entry NOP window and the exit latency.
// Assumes: load takes priority over counting; zero_o comes from the register.
module pds_dncnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load a new count, or step down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pds_entry_gate.sv
// Module: pds_entry_gate
// Decodes the scheduler and bank inputs into entry permission, exit request
// and power-down class.
// Assumes: the busy flags already cover each access up to the end of its
// postamble. Purely combinational.
module pds_entry_gate
    import pds_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8
) (
    input  logic                 pd_req,
    input  logic                 rd_busy,
    input  logic                 wr_busy,
    input  logic                 ref_due,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 entry_ok,
    output logic                 exit_req,
    output pds_mode_e            mode_class
);
    logic [NUM_BANKS:0] open_chain;

    // Ripple OR across banks: any open row selects active power-down
    assign open_chain[0] = 1'b0;
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign open_chain[b+1] = open_chain[b] | bank_open[b];
    end

    // Classify entry and exit conditions
    always_comb begin
        entry_ok   = pd_req && !rd_busy && !wr_busy && !ref_due;
        exit_req   = !pd_req || ref_due;
        mode_class = open_chain[NUM_BANKS] ? PDM_ACTIVE : PDM_PRECHARGE;
    end
endmodule

// File: rtl/mem_pd_sequencer.sv
// Module: mem_pd_sequencer (top)
// Drives the active-low DRAM clock enable, forces the post-entry and exit
// NOPs, blocks the scheduler until the exit latency has run out, and reports
// the power-down class.
// Assumes: cfg_tcke and cfg_tpdex are static while the block is out of
// ACTIVE. A value of zero behaves like one.
module mem_pd_sequencer
    import pds_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_tcke,
    input  logic [CNT_W-1:0]     cfg_tpdex,
    input  logic                 pd_req,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 rd_busy,
    input  logic                 wr_busy,
    input  logic                 ref_due,
    output logic                 cke_n,
    output logic                 cmd_block,
    output logic                 force_nop,
    output logic [1:0]           pd_mode
);
    localparam logic [CNT_W-1:0] NOP_LOAD = CNT_W'(PDS_POST_ENTRY_NOPS);

    pds_state_e state_q, state_d;
    pds_mode_e  mode_q, mode_class;
    logic       cke_n_q, exit_pend_q;
    logic       entry_ok, exit_req, entry_go, exit_go;
    logic       hold_zero, nop_zero, pdex_zero;
    logic [CNT_W-1:0] tcke_load, tpdex_load;

    // Convert lengths to down-counter loads, clamping zero to one cycle
    always_comb begin
        tcke_load  = (cfg_tcke  == '0) ? '0 : cfg_tcke  - 1'b1;
        tpdex_load = (cfg_tpdex == '0) ? '0 : cfg_tpdex - 1'b1;
    end

    pds_entry_gate #(.NUM_BANKS(NUM_BANKS)) u_gate (
        .pd_req     (pd_req),
        .rd_busy    (rd_busy),
        .wr_busy    (wr_busy),
        .ref_due    (ref_due),
        .bank_open  (bank_open),
        .entry_ok   (entry_ok),
        .exit_req   (exit_req),
        .mode_class (mode_class)
    );

    // Enable-line minimum hold, reloaded on every level change
    pds_dncnt #(.W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(entry_go || exit_go),
        .load_val(tcke_load), .zero_o(hold_zero)
    );

    // Forced NOP window after the entry cycle
    pds_dncnt #(.W(CNT_W)) u_nop (
        .clk(clk), .rst_n(rst_n), .load(entry_go),
        .load_val(NOP_LOAD), .zero_o(nop_zero)
    );

    // Exit latency before the scheduler is released
    pds_dncnt #(.W(CNT_W)) u_pdex (
        .clk(clk), .rst_n(rst_n), .load(exit_go),
        .load_val(tpdex_load), .zero_o(pdex_zero)
    );

    // Entry and exit triggers
    always_comb begin
        entry_go = (state_q == PDS_ACTIVE) && entry_ok && hold_zero;
        exit_go  = (state_q == PDS_DOWN) && (exit_pend_q || exit_req) && hold_zero;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PDS_ACTIVE:    if (entry_go)  state_d = PDS_ENTRY_NOP;
            PDS_ENTRY_NOP: if (nop_zero)  state_d = PDS_DOWN;
            PDS_DOWN:      if (exit_go)   state_d = PDS_EXIT_WAIT;
            PDS_EXIT_WAIT: if (pdex_zero) state_d = PDS_ACTIVE;
            default:                      state_d = PDS_ACTIVE;
        endcase
    end

    // State, enable line, captured class and latched exit request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= PDS_ACTIVE;
            cke_n_q     <= 1'b0;
            mode_q      <= PDM_NONE;
            exit_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (entry_go) begin
                cke_n_q <= 1'b1;
                mode_q  <= mode_class;
            end else if (exit_go) begin
                cke_n_q <= 1'b0;
                mode_q  <= PDM_NONE;
            end
            if (exit_go || state_q == PDS_ACTIVE || state_q == PDS_EXIT_WAIT)
                exit_pend_q <= 1'b0;
            else if (exit_req)
                exit_pend_q <= 1'b1;
        end
    end

    // Moore outputs
    always_comb begin
        cke_n     = cke_n_q;
        cmd_block = (state_q != PDS_ACTIVE);
        force_nop = (state_q == PDS_ENTRY_NOP) || (state_q == PDS_EXIT_WAIT);
        pd_mode   = mode_q;
    end
endmodule

// File: rtl/pds_checker.sv
// Module: pds_checker
// Port-level properties of the power-down sequencer. Bound to the top module.
// Assumes: cfg_tcke is stable while the block is powered down.
module pds_checker #(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned CNT_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CNT_W-1:0]     cfg_tcke,
    input logic                 pd_req,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 rd_busy,
    input logic                 wr_busy,
    input logic                 ref_due,
    input logic                 cke_n,
    input logic                 cmd_block,
    input logic                 force_nop,
    input logic [1:0]           pd_mode
);
    logic [15:0] held_q;
    logic        cke_prev_q;
    logic [15:0] need;

    // Count the cycles the enable line has kept its current level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= 16'hFFFF;
            cke_prev_q <= 1'b0;
        end else begin
            cke_prev_q <= cke_n;
            if (cke_n != cke_prev_q)   held_q <= 16'd1;
            else if (held_q != 16'hFFFF) held_q <= held_q + 16'd1;
        end
    end

    assign need = (cfg_tcke == '0) ? 16'd1 : 16'(cfg_tcke);

    a_r2_entry_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_n) |-> $past(pd_req && !rd_busy && !wr_busy && !ref_due));

    a_r3_mode_class: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_n) |-> (pd_mode == ($past(|bank_open) ? 2'b10 : 2'b01)));

    a_r4_entry_nops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_n) |-> force_nop ##1 force_nop ##1 force_nop ##1 !force_nop);

    a_r5_cke_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_n != cke_prev_q) |-> (held_q >= need));

    a_r7_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_n) |-> (force_nop && cmd_block && pd_mode == 2'b00));

    a_r8_block_down: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |-> cmd_block);
endmodule

bind mem_pd_sequencer pds_checker #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_pds_chk (
    .clk(clk), .rst_n(rst_n), .cfg_tcke(cfg_tcke), .pd_req(pd_req),
    .bank_open(bank_open), .rd_busy(rd_busy), .wr_busy(wr_busy),
    .ref_due(ref_due), .cke_n(cke_n), .cmd_block(cmd_block),
    .force_nop(force_nop), .pd_mode(pd_mode)
);

// File: tb/tb_mem_pd_sequencer.sv
module tb_mem_pd_sequencer;
    localparam int NB = 8;
    localparam int CW = 8;
    localparam logic [1:0] M_NONE = 2'b00, M_PRE = 2'b01, M_ACT = 2'b10;

    typedef struct {
        int         cyc;
        logic       cke;
        logic       blk;
        logic       nop;
        logic [1:0] mode;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] cfg_tcke = 8'd4, cfg_tpdex = 8'd3;
    logic pd_req = 1'b0, rd_busy = 1'b0, wr_busy = 1'b0, ref_due = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic cke_n, cmd_block, force_nop;
    logic [1:0] pd_mode;

    int cyc = 0, n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    exp_t expq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mem_pd_sequencer #(.NUM_BANKS(NB), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_tcke(cfg_tcke), .cfg_tpdex(cfg_tpdex),
        .pd_req(pd_req), .bank_open(bank_open), .rd_busy(rd_busy),
        .wr_busy(wr_busy), .ref_due(ref_due), .cke_n(cke_n),
        .cmd_block(cmd_block), .force_nop(force_nop), .pd_mode(pd_mode)
    );

    task automatic push(int c, logic k, logic b, logic n, logic [1:0] m, string t);
        exp_t e;
        e.cyc = c; e.cke = k; e.blk = b; e.nop = n; e.mode = m; e.tag = t;
        expq.push_back(e);
    endtask

    task automatic goto(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: pop expected items when their cycle comes up
    always @(negedge clk) begin
        while (expq.size() > 0 && expq[0].cyc <= cyc) begin
            exp_t e;
            e = expq.pop_front();
            n_chk++;
            if (e.cyc != cyc || cke_n !== e.cke || cmd_block !== e.blk ||
                force_nop !== e.nop || pd_mode !== e.mode) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got cke_n=%b blk=%b nop=%b mode=%b, expected cke_n=%b blk=%b nop=%b mode=%b (for cyc %0d)",
                         e.tag, cyc, cke_n, cmd_block, force_nop, pd_mode,
                         e.cke, e.blk, e.nop, e.mode, e.cyc);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        // R1: idle outputs right after reset release
        push(cyc + 1, 0, 0, 0, M_NONE, "R1");
        rst_n = 1'b1;
        goto(cyc + 3);

        // Scenario A: precharge entry, exit on request drop, tPDEX=3
        c = cyc;
        push(c+1, 1, 1, 1, M_PRE, "R3");
        push(c+3, 1, 1, 1, M_PRE, "R4");
        push(c+4, 1, 1, 0, M_PRE, "R4");
        push(c+5, 1, 1, 0, M_PRE, "R8");
        push(c+6, 0, 1, 1, M_NONE, "R7");
        push(c+8, 0, 1, 1, M_NONE, "R8");
        push(c+9, 0, 0, 0, M_NONE, "R8");
        pd_req = 1'b1;
        goto(c+5); pd_req = 1'b0;
        goto(c+12);

        // Scenario B: busy flags hold off entry, active class, refresh exit
        c = cyc;
        push(c+1, 0, 0, 0, M_NONE, "R2");
        push(c+4, 0, 0, 0, M_NONE, "R2");
        push(c+5, 1, 1, 1, M_ACT, "R3");
        push(c+7, 1, 1, 1, M_ACT, "R4");
        push(c+8, 1, 1, 0, M_ACT, "R9");
        push(c+9, 0, 1, 1, M_NONE, "R9");
        push(c+11, 0, 1, 1, M_NONE, "R8");
        push(c+12, 0, 0, 0, M_NONE, "R8");
        pd_req = 1'b1; bank_open = 8'h04; rd_busy = 1'b1;
        goto(c+2); rd_busy = 1'b0; wr_busy = 1'b1;
        goto(c+4); wr_busy = 1'b0;
        goto(c+5); ref_due = 1'b1;
        goto(c+6); ref_due = 1'b0;
        goto(c+9); pd_req = 1'b0;
        goto(c+16);

        // Scenario C: refresh blocks entry, latched short exit, tCKE holds re-entry
        c = cyc;
        cfg_tpdex = 8'd1; bank_open = '0;
        push(c+2, 0, 0, 0, M_NONE, "R9");
        pd_req = 1'b1; ref_due = 1'b1;
        goto(c+2); ref_due = 1'b0;
        c = c + 2;
        push(c+1, 1, 1, 1, M_PRE, "R3");
        push(c+4, 1, 1, 0, M_PRE, "R6");
        push(c+5, 0, 1, 1, M_NONE, "R6");
        push(c+6, 0, 0, 0, M_NONE, "R8");
        push(c+8, 0, 0, 0, M_NONE, "R5");
        push(c+9, 1, 1, 1, M_PRE, "R5");
        push(c+12, 1, 1, 0, M_PRE, "R5");
        push(c+13, 0, 1, 1, M_NONE, "R6");
        goto(c+1); pd_req = 1'b0;
        goto(c+3); pd_req = 1'b1;
        goto(c+9); pd_req = 1'b0;
        goto(c+16);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule